// File: doc/BRIEF.md
# Filtered Event Status Queue

This block keeps a running record of message events that are allowed to raise an interrupt. It stores them in a circular store of 64 words. Each accepted event takes up two adjacent words. The first word holds the event bits that passed the masks. The second word holds the identifier that came with the event. Entries are written in the order the events arrive, so software can read backwards from the write pointer to rebuild what happened and in which order.

Two gates decide whether an event is recorded. The first gate is a pair of mask words: one enables the lower half of the event bits and the other enables the upper half. An event is recorded only when at least one of its bits survives the masks. The second gate is a two-bit message filter, which accepts messages flagged good, messages flagged bad, or both.

The host reads any word by index through a combinational read port. It reads the write pointer to find the newest entry. The pointer runs past word 63 back to word 0 without stalling, and the oldest entries are overwritten. After each complete entry, a single-cycle request output pulses.

Top module: `evt_status_queue`

## Requirements
- R1: After reset, the write pointer is 0, the request output is 0, and every one of the 64 words reads 0.
- R2: An event that is accepted at a clock edge writes its status word at the current pointer on that edge. On the next edge it writes its identifier at the following word. The pointer advances by one on each of these two edges.
- R3: The stored status word is the event bits with bits 7..0 ANDed with the low mask and bits 15..8 ANDed with the high mask.
- R4: An event whose bits are all cleared by the masks writes nothing and leaves the pointer unchanged.
- R5: Filter bit 0 set accepts events flagged good (flag = 1). Filter bit 1 set accepts events flagged bad (flag = 0). An event that the filter rejects writes nothing and leaves the pointer unchanged.
- R6: The pointer wraps from 63 to 0 with no stall, and new entries overwrite the oldest words.
- R7: The request output is high for exactly one cycle, beginning at the edge that writes an entry's second word.
- R8: An event presented in the cycle in which an entry's second word is written is ignored.
- R9: The read data equals the word at the read index, and reading has no effect on the pointer or the contents.
- R10: Successive accepted events occupy successive word pairs, oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Event strobe, one cycle per event |
| evtBits | input | 16 | Event status bits |
| evtMsgOk | input | 1 | 1 = message good, 0 = message bad |
| evtId | input | 16 | Message identifier stored in the second word |
| maskLow | input | 8 | Enable for event bits 7..0 |
| maskHigh | input | 8 | Enable for event bits 15..8 |
| filterMode | input | 2 | Bit 0 accepts good messages, bit 1 accepts bad messages |
| rdIdx | input | 6 | Host read index |
| rdData | output | 16 | Word at rdIdx |
| wrPtr | output | 6 | Next word to be written |
| irqReq | output | 1 | One-cycle pulse after each complete entry |

## Verification
On every cycle, the assertions check the following. The pointer moves only forward, in single steps, with wrap. An odd pointer, which means an entry is half written, always advances on the next edge. The request never lasts longer than one cycle, and it coincides with a pointer step. Events that the masks or the filter reject leave the pointer where it was.

Only the bench scenarios can show the stored contents. These include the masked status value, the identifier in the second word, the pair ordering and the overwrite after a wrap. They also include the reset contents of all words and the fact that an event arriving during a second-word write leaves no trace.

// File: rtl/esq_pkg.sv
package esq_pkg;

  typedef struct packed {
    logic wrStatus;
    logic wrIdent;
  } esqStrobe_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } esqState_t;

endpackage

// File: rtl/esq_ctrl.sv
module esq_ctrl
  import esq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtValid,
  input  logic       evtMsgOk,
  input  logic [1:0] filterMode,
  input  logic       anyEnabled,
  output esqStrobe_t strobe
);

  esqState_t state, stateNext;
  logic filterPass;
  logic accept;

  // good messages pass on bit 0, bad messages pass on bit 1
  assign filterPass = evtMsgOk ? filterMode[0] : filterMode[1];
  assign accept     = evtValid && anyEnabled && filterPass;

  always_comb begin
    stateNext       = state;
    strobe.wrStatus = 1'b0;
    strobe.wrIdent  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          strobe.wrStatus = 1'b1;
          stateNext       = ST_SECOND;
        end
      end
      ST_SECOND: begin
        // second word goes out; any event now is dropped
        strobe.wrIdent = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/esq_data.sv
module esq_data
  import esq_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int QUEUE_WORDS = 64,
  localparam int PTR_W      = $clog2(QUEUE_WORDS),
  localparam int HALF_W     = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  esqStrobe_t        strobe,
  input  logic [WORD_W-1:0] evtBits,
  input  logic [WORD_W-1:0] evtId,
  input  logic [HALF_W-1:0] maskLow,
  input  logic [HALF_W-1:0] maskHigh,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic              anyEnabled,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [WORD_W-1:0] rdData,
  output logic              irqReq
);

  logic [WORD_W-1:0] maskedBits;
  logic [WORD_W-1:0] idHold;
  logic [WORD_W-1:0] store [QUEUE_WORDS];

  for (genvar h = 0; h < 2; h++) begin : g_half
    if (h == 0) begin : g_lo
      assign maskedBits[h*HALF_W +: HALF_W] = evtBits[h*HALF_W +: HALF_W] & maskLow;
    end else begin : g_hi
      assign maskedBits[h*HALF_W +: HALF_W] = evtBits[h*HALF_W +: HALF_W] & maskHigh;
    end
  end

  assign anyEnabled = |maskedBits;
  assign rdData     = store[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      idHold <= '0;
      irqReq <= 1'b0;
      for (int i = 0; i < QUEUE_WORDS; i++) store[i] <= '0;
    end else begin
      irqReq <= strobe.wrIdent;
      if (strobe.wrStatus) begin
        store[wrPtr] <= maskedBits;
        idHold       <= evtId;
        wrPtr        <= wrPtr + 1'b1;
      end else if (strobe.wrIdent) begin
        store[wrPtr] <= idHold;
        wrPtr        <= wrPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/evt_status_queue.sv
module evt_status_queue
  import esq_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int QUEUE_WORDS = 64,
  localparam int PTR_W      = $clog2(QUEUE_WORDS),
  localparam int HALF_W     = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [WORD_W-1:0] evtBits,
  input  logic              evtMsgOk,
  input  logic [WORD_W-1:0] evtId,
  input  logic [HALF_W-1:0] maskLow,
  input  logic [HALF_W-1:0] maskHigh,
  input  logic [1:0]        filterMode,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdData,
  output logic [PTR_W-1:0]  wrPtr,
  output logic              irqReq
);

  esqStrobe_t strobe;
  logic       anyEnabled;

  esq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evtValid   (evtValid),
    .evtMsgOk   (evtMsgOk),
    .filterMode (filterMode),
    .anyEnabled (anyEnabled),
    .strobe     (strobe)
  );

  esq_data #(
    .WORD_W      (WORD_W),
    .QUEUE_WORDS (QUEUE_WORDS)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .evtBits    (evtBits),
    .evtId      (evtId),
    .maskLow    (maskLow),
    .maskHigh   (maskHigh),
    .rdIdx      (rdIdx),
    .anyEnabled (anyEnabled),
    .wrPtr      (wrPtr),
    .rdData     (rdData),
    .irqReq     (irqReq)
  );

endmodule

// File: rtl/esq_checker.sv
module esq_checker #(
  parameter int WORD_W      = 16,
  parameter int QUEUE_WORDS = 64,
  localparam int PTR_W      = $clog2(QUEUE_WORDS),
  localparam int HALF_W     = WORD_W / 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtValid,
  input logic [WORD_W-1:0] evtBits,
  input logic              evtMsgOk,
  input logic [HALF_W-1:0] maskLow,
  input logic [HALF_W-1:0] maskHigh,
  input logic [1:0]        filterMode,
  input logic [PTR_W-1:0]  wrPtr,
  input logic              irqReq
);

  logic noBitEnabled;
  logic filterBlocks;
  assign noBitEnabled = ((evtBits & {maskHigh, maskLow}) == '0);
  assign filterBlocks = evtMsgOk ? !filterMode[0] : !filterMode[1];

  // R2, R6: pointer only steps forward by one, wrapping
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr != $past(wrPtr)) |-> (wrPtr == PTR_W'($past(wrPtr) + 1'b1)));

  // R2: half-written entry always completes on the next edge
  p_second_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr[0] |=> (wrPtr == PTR_W'($past(wrPtr) + 1'b1)));

  // R7: request lasts one cycle
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);

  // R7: request coincides with the second-word pointer step
  p_irq_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> (wrPtr == PTR_W'($past(wrPtr) + 1'b1)) && !wrPtr[0]);

  // R4: fully masked event makes no entry
  p_masked_none_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && noBitEnabled && !wrPtr[0]) |=> (wrPtr == $past(wrPtr)));

  // R5: filtered event makes no entry
  p_filtered_none_r5: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && filterBlocks && !wrPtr[0]) |=> (wrPtr == $past(wrPtr)));

endmodule

bind evt_status_queue esq_checker #(
  .WORD_W      (WORD_W),
  .QUEUE_WORDS (QUEUE_WORDS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evtValid   (evtValid),
  .evtBits    (evtBits),
  .evtMsgOk   (evtMsgOk),
  .maskLow    (maskLow),
  .maskHigh   (maskHigh),
  .filterMode (filterMode),
  .wrPtr      (wrPtr),
  .irqReq     (irqReq)
);

// File: tb/evt_status_queue_test.sv
module evt_status_queue_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic [15:0] evtBits = '0;
  logic        evtMsgOk = 1'b1;
  logic [15:0] evtId = '0;
  logic [7:0]  maskLow = 8'hFF;
  logic [7:0]  maskHigh = 8'hFF;
  logic [1:0]  filterMode = 2'b11;
  logic [5:0]  rdIdx = '0;
  logic [15:0] rdData;
  logic [5:0]  wrPtr;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  logic [15:0] expMem [64];
  int expPtr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_status_queue uut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtBits(evtBits),
    .evtMsgOk(evtMsgOk), .evtId(evtId), .maskLow(maskLow), .maskHigh(maskHigh),
    .filterMode(filterMode), .rdIdx(rdIdx), .rdData(rdData), .wrPtr(wrPtr),
    .irqReq(irqReq)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic readWord(input int idx, output logic [15:0] val);
    rdIdx = 6'(idx);
    #1;
    val = rdData;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic pushEntry(input logic [15:0] bits, input logic ok,
                           input logic [15:0] id, input string req);
    logic [15:0] expStat;
    logic [15:0] v;
    int p;
    p = expPtr;
    expStat = {bits[15:8] & maskHigh, bits[7:0] & maskLow};
    @(negedge clk);
    evtValid = 1'b1; evtBits = bits; evtMsgOk = ok; evtId = id;
    @(negedge clk);
    evtValid = 1'b0;
    checkVal(req, "pointer after status word", 16'(wrPtr), 16'((p + 1) % 64));
    readWord(p, v);
    checkVal(req, "status word", v, expStat);
    checkVal(req, "request before second word", 16'(irqReq), 16'd0);
    @(negedge clk);
    checkVal(req, "pointer after identifier", 16'(wrPtr), 16'((p + 2) % 64));
    readWord((p + 1) % 64, v);
    checkVal(req, "identifier word", v, id);
    checkVal("R7", "request after entry", 16'(irqReq), 16'd1);
    @(negedge clk);
    checkVal("R7", "request one cycle only", 16'(irqReq), 16'd0);
    expMem[p] = expStat;
    expMem[(p + 1) % 64] = id;
    expPtr = (p + 2) % 64;
  endtask

  task automatic rejectEvent(input logic [15:0] bits, input logic ok,
                             input logic [15:0] id, input string req);
    @(negedge clk);
    evtValid = 1'b1; evtBits = bits; evtMsgOk = ok; evtId = id;
    @(negedge clk);
    evtValid = 1'b0;
    checkVal(req, "pointer held after rejected event", 16'(wrPtr), 16'(expPtr));
    @(negedge clk);
    checkVal(req, "pointer still held", 16'(wrPtr), 16'(expPtr));
    checkVal(req, "no request for rejected event", 16'(irqReq), 16'd0);
  endtask

  task automatic testReset();
    logic [15:0] v;
    checkVal("R1", "pointer at reset", 16'(wrPtr), 16'd0);
    checkVal("R1", "request at reset", 16'(irqReq), 16'd0);
    for (int i = 0; i < 64; i++) begin
      readWord(i, v);
      checkVal("R1", "word cleared", v, 16'd0);
      expMem[i] = 16'd0;
    end
  endtask

  task automatic testBasic();
    logic [15:0] v;
    pushEntry(16'h0081, 1'b1, 16'hBEEF, "R2");
    pushEntry(16'h4002, 1'b0, 16'h1234, "R10");
    readWord(0, v); checkVal("R10", "first entry status", v, 16'h0081);
    readWord(1, v); checkVal("R10", "first entry id", v, 16'hBEEF);
    readWord(2, v); checkVal("R10", "second entry status", v, 16'h4002);
    readWord(3, v); checkVal("R10", "second entry id", v, 16'h1234);
  endtask

  task automatic testMask();
    logic [15:0] v;
    maskLow = 8'h0F; maskHigh = 8'hF0;
    pushEntry(16'hFFFF, 1'b1, 16'h5A5A, "R3");
    readWord(expPtr - 2, v);
    checkVal("R3", "masked halves", v, 16'hF00F);
    rejectEvent(16'h0FF0, 1'b1, 16'hDEAD, "R4");
    maskLow = 8'h00; maskHigh = 8'h00;
    rejectEvent(16'hFFFF, 1'b1, 16'hDEAD, "R4");
    maskLow = 8'hFF; maskHigh = 8'hFF;
  endtask

  task automatic testFilter();
    filterMode = 2'b01;
    rejectEvent(16'h0001, 1'b0, 16'h0BAD, "R5");
    pushEntry(16'h0001, 1'b1, 16'h0600, "R5");
    filterMode = 2'b10;
    rejectEvent(16'h0001, 1'b1, 16'h0BAD, "R5");
    pushEntry(16'h0002, 1'b0, 16'h0601, "R5");
    filterMode = 2'b00;
    rejectEvent(16'h0003, 1'b1, 16'h0BAD, "R5");
    rejectEvent(16'h0003, 1'b0, 16'h0BAD, "R5");
    filterMode = 2'b11;
  endtask

  task automatic testIgnore();
    logic [15:0] v;
    int p;
    p = expPtr;
    @(negedge clk);
    evtValid = 1'b1; evtBits = 16'h0010; evtMsgOk = 1'b1; evtId = 16'h1111;
    @(negedge clk);
    evtBits = 16'h0020; evtId = 16'h2222;
    @(negedge clk);
    evtValid = 1'b0;
    checkVal("R8", "pointer after entry", 16'(wrPtr), 16'((p + 2) % 64));
    readWord((p + 1) % 64, v);
    checkVal("R8", "identifier of first event kept", v, 16'h1111);
    @(negedge clk);
    checkVal("R8", "late event left no entry", 16'(wrPtr), 16'((p + 2) % 64));
    checkVal("R8", "no second request", 16'(irqReq), 16'd0);
    expMem[p] = 16'h0010;
    expMem[(p + 1) % 64] = 16'h1111;
    expPtr = (p + 2) % 64;
  endtask

  task automatic testRead();
    logic [15:0] v;
    for (int i = 63; i >= 0; i--) begin
      readWord(i, v);
      checkVal("R9", "read matches model", v, expMem[i]);
    end
    @(negedge clk);
    checkVal("R9", "pointer unchanged by reads", 16'(wrPtr), 16'(expPtr));
  endtask

  task automatic testWrap();
    int start;
    start = expPtr;
    for (int i = 0; i < 33; i++) begin
      pushEntry(16'(16'h0100 + i), 1'b1, 16'(16'hA000 + i), "R6");
    end
    checkVal("R6", "pointer after wrap", 16'(wrPtr), 16'((start + 66) % 64));
    testRead();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testMask();
    testFilter();
    testIgnore();
    testRead();
    testWrap();
    summary();
    $finish;
  end

endmodule